// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-side controller of a byte-wide memory of 32,768 locations that sits on a two-wire serial bus as a slave. It samples the serial clock and data lines with the fast system clock and recognises the bus framing events. It takes in the device selection byte and the word address, and then either forwards data bytes to a write-commit unit or fetches bytes from a memory read port and shifts them onto the bus. The block only pulls the data line low, through an open-drain enable, for acknowledge bits and for read data zeros.

A single address pointer lives across transactions. Reads advance it linearly through the whole array and wrap to zero. Writes advance only its six page bits, so they wrap within a 64-byte page. The write-commit unit reports a busy flag while it programs the array. During that time the block refuses its own device byte, so a master can poll until the write has finished.

Top module: `slv_twowire`

## Requirements
- R1: A fall of the data line while the clock line is high (a start) begins reception of a device byte at any point, including in the middle of a byte. A rise of the data line while the clock line is high (a stop) returns the block to idle.
- R2: Bits of a byte arrive most significant first, sampled on clock rises. The device byte matches when bits 7..3 equal 10100 and bits 2..1 equal `strap_a`. Bit 0 selects a read when 1. On a mismatch the block gives no acknowledge and ignores the bus until the next start.
- R3: The block acknowledges every byte it accepts by asserting `sda_oe` for the whole ninth clock. `sda_oe` only changes while the clock line is low.
- R4: A write carries two word-address bytes, high byte first. Bit 7 of the high byte is ignored, which gives a 15-bit address.
- R5: Each data byte of a write pulses `wr_stb` for one cycle with `wr_addr` and `wr_data`. After each byte the address advances in its low 6 bits only, so it wraps from the end of a 64-byte page to the start of the same page.
- R6: A stop or a repeated start that ends a write with at least one data byte produces exactly one `commit_req` pulse. A write that carries only an address (a dummy write) produces none.
- R7: While `commit_busy` is high, the block does not acknowledge its device byte, and it issues no `wr_stb`.
- R8: A read returns the byte at the pointer, which then advances by one across the whole array, wrapping from 0x7FFF to 0x0000. The pointer is kept between transactions, so a read with no address loaded returns the byte after the last one accessed.
- R9: In a read, each master acknowledge makes the block send the next byte. A master no-acknowledge makes it release the data line and go idle.
- R10: After reset, `sda_oe`, `rd_req`, `wr_stb` and `commit_req` are low, and the address pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| strap_a | input | 2 | Board strap bits compared with device byte bits 2..1 |
| rd_req | output | 1 | One-cycle read request to the memory port |
| rd_addr | output | 15 | Read address, valid with `rd_req` |
| rd_data | input | 8 | Read data, valid the cycle after `rd_req` |
| wr_stb | output | 1 | One-cycle strobe of a received data byte |
| wr_addr | output | 15 | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| commit_req | output | 1 | One-cycle request to program the staged bytes |
| commit_busy | input | 1 | High while the write-commit unit is programming |

## Verification
The assertions assume that the master changes the data line only well after a clock fall, except for starts and stops. They also assume that the clock low phase lasts longer than the synchronizer delay, and that `commit_busy` rises only after a commit request. The bench's bit-level master holds each clock phase for eight or more system cycles and moves data in the middle of the low phase. Its write-commit model raises busy only in response to `commit_req`, which keeps every run inside those assumptions.

// File: rtl/slv_pkg.sv
package slv_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] DEV_TAG = 5'b10100;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_e;
  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DATA} kind_e;
endpackage

// File: rtl/slv_line_sync.sv
module slv_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops followed by one history flop
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], line_in};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/slv_addr_ctr.sv
module slv_addr_ctr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc_lin,
  input  logic              inc_pg,
  output logic [ADDR_W-1:0] cur
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] col_nxt;
  assign col_nxt = cur[PAGE_W-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)          cur <= '0;
    else if (ld)      cur <= ld_val;
    else if (inc_lin) cur <= cur + 1'b1;
    else if (inc_pg)  cur <= {cur[ADDR_W-1:ADDR_W-ROW_W], col_nxt};
  end
endmodule

// File: rtl/slv_twowire.sv
module slv_twowire
  import slv_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [1:0]        strap_a,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit_req,
  input  logic              commit_busy
);
  localparam int HI_KEEP = ADDR_W - BYTE_W;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  slv_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .line_in(scl_in),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));
  slv_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .line_in(sda_in),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  logic bus_start, bus_stop, quiet;
  assign bus_start = scl_lvl & sda_fall;
  assign bus_stop  = scl_lvl & sda_rise;
  assign quiet     = ~bus_start & ~bus_stop;

  st_e                st;
  kind_e              kind, nkind;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  rx_sh, tx_sh;
  logic [HI_KEEP-1:0] hi_q;
  logic               rd_mode, macked, wrote, rd_pend;

  logic              byte_done, dev_match, ack_fire, rd_fire;
  logic              ctr_ld, ctr_pg;
  logic [ADDR_W-1:0] ld_val, cur;

  always_comb begin
    byte_done = quiet && (st == ST_RX) && scl_fall && (cnt == LAST);
    dev_match = (rx_sh[7:3] == DEV_TAG) && (rx_sh[2:1] == strap_a) && !commit_busy;
    ack_fire  = quiet && (st == ST_MACK) && scl_rise && !sda_lvl;
    rd_fire   = (byte_done && (kind == K_DEV) && dev_match && rx_sh[0]) || ack_fire;
    ctr_ld    = byte_done && (kind == K_ALO);
    ctr_pg    = byte_done && (kind == K_DATA);
    ld_val    = {hi_q, rx_sh};
  end

  slv_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst(rst), .ld(ctr_ld), .ld_val(ld_val),
    .inc_lin(rd_fire), .inc_pg(ctr_pg), .cur(cur));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; kind <= K_DEV; nkind <= K_DEV; cnt <= '0;
      rx_sh <= '0; tx_sh <= '0; hi_q <= '0;
      rd_mode <= 1'b0; macked <= 1'b0; wrote <= 1'b0; rd_pend <= 1'b0;
      sda_oe <= 1'b0; rd_req <= 1'b0; rd_addr <= '0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; commit_req <= 1'b0;
    end else begin
      rd_req     <= rd_fire;
      rd_pend    <= rd_fire;
      wr_stb     <= 1'b0;
      commit_req <= 1'b0;
      if (rd_fire) rd_addr <= cur;
      if (rd_pend) tx_sh <= rd_data;

      if (!quiet) begin
        // framing event: abandon whatever was in progress
        sda_oe <= 1'b0;
        cnt    <= '0;
        kind   <= K_DEV;
        if (wrote) commit_req <= 1'b1;
        wrote  <= 1'b0;
        st     <= bus_start ? ST_RX : ST_IDLE;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt != LAST) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (byte_done) begin
              sda_oe <= 1'b1;
              st     <= ST_ACK;
              case (kind)
                K_DEV: begin
                  rd_mode <= rx_sh[0];
                  nkind   <= K_AHI;
                  if (!dev_match) begin
                    sda_oe <= 1'b0;
                    st     <= ST_IDLE;
                  end
                end
                K_AHI: begin
                  hi_q  <= rx_sh[HI_KEEP-1:0];
                  nkind <= K_ALO;
                end
                K_ALO: nkind <= K_DATA;
                default: begin
                  wr_stb  <= 1'b1;
                  wr_addr <= cur;
                  wr_data <= rx_sh;
                  wrote   <= 1'b1;
                  nkind   <= K_DATA;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_DEV && rd_mode) begin
                st     <= ST_TX;
                sda_oe <= ~tx_sh[BYTE_W-1];
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
                kind   <= nkind;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-2];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              macked <= !sda_lvl;
            end else if (scl_fall) begin
              cnt <= '0;
              if (macked) begin
                st     <= ST_TX;
                sda_oe <= ~tx_sh[BYTE_W-1];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/slv_twowire_chk.sv
module slv_twowire_chk (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic sda_oe,
  input logic rd_req,
  input logic wr_stb,
  input logic commit_req,
  input logic commit_busy
);
  // R3: the enable moves only while the clock line is low
  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_in);

  // R6: a commit request is a single-cycle pulse
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    commit_req |=> !commit_req);

  // R7: no data byte is forwarded while the commit unit is busy
  p_no_wr_busy_r7: assert property (@(posedge clk) disable iff (rst)
    commit_busy |-> !wr_stb);

  // R8: a read request is a single-cycle pulse
  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R5: reads and writes never strobe together
  p_rw_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && rd_req));

  // R10: outputs are quiet in the cycle after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe && !rd_req && !wr_stb && !commit_req));
endmodule

bind slv_twowire slv_twowire_chk u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe),
  .rd_req(rd_req), .wr_stb(wr_stb), .commit_req(commit_req),
  .commit_busy(commit_busy));

// File: tb/slv_twowire_tb_top.sv
module slv_twowire_tb_top;
  localparam int Q  = 8;
  localparam int AW = 15;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, rd_req, wr_stb, commit_req;
  logic commit_busy = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data = 8'h00, wr_data;
  wire sda_line = sda_m & ~sda_oe;

  slv_twowire dut_i (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_a(strap), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_req(commit_req), .commit_busy(commit_busy));

  int checks = 0, errors = 0, commits = 0, busy_cnt = 0;
  bit [7:0] store[int];
  bit [7:0] exp_store[int];
  int exp_ptr = 0;
  int pend_a[$], pend_d[$], log_a[$], log_d[$];
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  function automatic bit [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic bit [7:0] fetch(int a);
    return store.exists(a) ? store[a] : pat(a);
  endfunction
  function automatic bit [7:0] exp_rd(int a);
    return exp_store.exists(a) ? exp_store[a] : pat(a);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory port, commit unit and per-clock line discipline monitor
  always @(negedge clk) begin
    if (rd_req) rd_data = fetch(int'(rd_addr));
    if (wr_stb) begin
      pend_a.push_back(int'(wr_addr)); pend_d.push_back(int'(wr_data));
      log_a.push_back(int'(wr_addr));  log_d.push_back(int'(wr_data));
    end
    if (commit_req) begin
      commits++; busy_cnt = 300; commit_busy = 1'b1;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) begin
        foreach (pend_a[i]) store[pend_a[i]] = 8'(pend_d[i]);
        pend_a.delete(); pend_d.delete();
        commit_busy = 1'b0;
      end
    end
    if (!rst) begin
      checks++;
      if (prev_scl && scl_m && sda_oe !== prev_oe) begin
        errors++;
        $display("FAIL R3: sda_oe moved with clock high, got %0b expected %0b", sda_oe, prev_oe);
      end
    end
    prev_scl = scl_m; prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic start_c();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic stop_c();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic send(input logic [7:0] v, output bit ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = !x;
  endtask
  task automatic recv(output logic [7:0] v, input bit mack);
    logic x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); v[i] = x; end
    put_bit(!mack);
  endtask
  task automatic wait_idle();
    while (commit_busy) tick(1);
    tick(4);
  endtask
  task automatic exp_read(output bit [7:0] e);
    e = exp_rd(exp_ptr);
    exp_ptr = (exp_ptr + 1) & AMASK;
  endtask
  task automatic set_ptr(input int hi, input int lo);
    exp_ptr = ((hi & 127) << 8) | lo;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1: watchdog expired, got hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] v;
    bit [7:0] e;
    int c0, base;
    tick(4); rst = 1'b0; tick(3);

    // R10 reset state
    chk(sda_oe == 1'b0, "R10 sda_oe", sda_oe, 0);
    chk(!rd_req && !wr_stb && !commit_req, "R10 strobes", {rd_req, wr_stb, commit_req}, 0);

    // R10/R8 pointer starts at 0: current-address read
    start_c(); send(8'hA5, a); chk(a, "R2 read select ack", a, 1);
    recv(v, 0); exp_read(e); chk(v == e, "R10 first read at 0", v, e);
    chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    stop_c();

    // R2 mismatches: wrong strap, wrong tag, later bytes ignored
    start_c(); send(8'hA0, a); chk(!a, "R2 strap mismatch nack", a, 0);
    send(8'h00, a); chk(!a, "R2 ignored until start", a, 0); stop_c();
    start_c(); send(8'hB4, a); chk(!a, "R2 tag mismatch nack", a, 0); stop_c();

    // R3/R4/R5/R6 byte write
    c0 = commits; base = log_a.size();
    start_c(); send(8'hA4, a); chk(a, "R3 dev ack", a, 1);
    send(8'h00, a); chk(a, "R4 high addr ack", a, 1);
    send(8'h10, a); chk(a, "R4 low addr ack", a, 1);
    send(8'hA5, a); chk(a, "R3 data ack", a, 1);
    stop_c(); tick(4);
    exp_store[16] = 8'hA5; exp_ptr = 17;
    chk(log_a.size() == base + 1 && log_a[base] == 16 && log_d[base] == 8'hA5,
        "R5 strobe addr", log_a[base], 16);
    chk(commits == c0 + 1, "R6 one commit", commits - c0, 1);

    // R7 polling while busy
    start_c(); send(8'hA4, a); chk(!a, "R7 busy nack", a, 0); stop_c();
    wait_idle();
    c0 = commits;
    start_c(); send(8'hA4, a); chk(a, "R7 ack after busy", a, 1); stop_c(); tick(4);
    chk(commits == c0, "R6 no commit without data", commits - c0, 0);

    // R8 random read of 0x0010, then current read
    c0 = commits;
    start_c(); send(8'hA4, a); send(8'h00, a); send(8'h10, a);
    start_c(); send(8'hA5, a); chk(a, "R8 read ack", a, 1);
    set_ptr(0, 16); recv(v, 0); exp_read(e); chk(v == e, "R8 random read", v, e);
    stop_c(); tick(4);
    chk(commits == c0, "R6 dummy write no commit", commits - c0, 0);
    start_c(); send(8'hA5, a); recv(v, 0); exp_read(e);
    chk(v == e, "R8 current address read", v, e); stop_c();

    // R5 page write wraps within page
    base = log_a.size();
    start_c(); send(8'hA4, a); send(8'h01, a); send(8'h3E, a);
    send(8'h11, a); send(8'h22, a); send(8'h33, a); send(8'h44, a); stop_c(); tick(4);
    exp_store[318] = 8'h11; exp_store[319] = 8'h22; exp_store[256] = 8'h33; exp_store[257] = 8'h44;
    chk(log_a[base+2] == 256, "R5 page wrap address", log_a[base+2], 256);
    chk(log_a[base+3] == 257 && log_d[base+3] == 8'h44, "R5 after wrap", log_a[base+3], 257);
    wait_idle();

    // R9 sequential read from 0x013E runs linearly
    start_c(); send(8'hA4, a); send(8'h01, a); send(8'h3E, a);
    start_c(); send(8'hA5, a); set_ptr(1, 62);
    for (int i = 0; i < 4; i++) begin
      recv(v, i != 3); exp_read(e); chk(v == e, "R9 sequential byte", v, e);
    end
    stop_c();
    start_c(); send(8'hA4, a); send(8'h01, a); send(8'h00, a);
    start_c(); send(8'hA5, a); set_ptr(1, 0); recv(v, 0); exp_read(e);
    chk(v == e, "R5 wrapped byte stored", v, e); stop_c();

    // R4/R8 top bit ignored, read wraps over array end
    start_c(); send(8'hA4, a); send(8'hFF, a); send(8'hFE, a);
    start_c(); send(8'hA5, a); set_ptr(255, 254);
    for (int i = 0; i < 3; i++) begin
      recv(v, i != 2); exp_read(e); chk(v == e, "R8 array wrap", v, e);
    end
    stop_c();

    // R1 start in the middle of a byte restarts reception
    start_c(); put_bit(1); put_bit(0); put_bit(1); put_bit(0);
    start_c(); send(8'hA5, a); chk(a, "R1 abort then ack", a, 1);
    recv(v, 0); exp_read(e); chk(v == e, "R1 read after abort", v, e);
    stop_c(); tick(4);
    chk(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule